// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block runs the hardware handshake for a single serial channel. On the receive side it watches the fill level of the receive FIFO. When the FIFO is close to full, it deasserts the active-low request-to-send line so that the far end stops sending. It asserts the line again once the FIFO has drained. Two separate thresholds set these points, which gives hysteresis, so the line does not chatter around a single level. On the transmit side it takes in the far end's active-low clear-to-send line and turns it into a transmit-permit signal for the local transmitter. That permit changes only at character boundaries, so a character that has already started is always finished.

The two halves have independent enables. When automatic request-to-send is off, the line follows a software-held modem control bit. When automatic clear-to-send is off, the transmitter is always permitted. With both halves on and the local request-to-send looped back to the local clear-to-send, the transmitter cannot fill the receive FIFO past its halt level by more than the characters already in flight. Receive overrun is therefore ruled out.

Top module: `hsk_flow_ctrl`

## Requirements
- R1: While `rst_n` is low, the hysteresis state is "room available", so `rts_n` is 0 when `rts_auto_en` is 1. The transmit gate is closed, so `tx_permit` is 0 when `cts_auto_en` is 1. The clear-to-send synchronizer holds the inactive value 1.
- R2: With `rts_auto_en` at 1, a clock edge at which `rx_fill >= halt_lvl` makes `rts_n` 1 from that edge on.
- R3: With `rts_auto_en` at 1, a clock edge at which `rx_fill <= resume_lvl` and `rx_fill < halt_lvl` makes `rts_n` 0 from that edge on.
- R4: With `rx_fill` strictly between `resume_lvl` and `halt_lvl`, the hysteresis state and `rts_n` keep their previous value.
- R5: With `rts_auto_en` at 0, `rts_n` is the inverse of `sw_rts` in the same cycle, whatever the fill level.
- R6: `cts_n` passes through a chain of SYNC_STAGES flops, resetting to 1, before any use. A change on `cts_n` becomes visible to the transmit gate only after SYNC_STAGES clock edges.
- R7: With `cts_auto_en` at 1, `tx_permit` is loaded with the synchronized clear-to-send state (1 when active low) only at a clock edge where `char_bound` is 1. At all other edges it holds.
- R8: With `cts_auto_en` at 0, `tx_permit` is 1 regardless of `cts_n` and `char_bound`.
- R9: When both threshold conditions hold at once (`halt_lvl <= resume_lvl`), the halt condition wins and `rts_n` goes to 1.
- R10: With both enables at 1 and `rts_n` looped to `cts_n`, `tx_permit` drops to 0 at the first `char_bound` edge that comes more than SYNC_STAGES edges after the fill reaches `halt_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rts_auto_en | input | 1 | 1 drives `rts_n` from the FIFO fill level |
| cts_auto_en | input | 1 | 1 gates the transmitter with clear-to-send |
| sw_rts | input | 1 | Software request bit used when automatic RTS is off (1 = request) |
| halt_lvl | input | CNT_W | Fill level at or above which the request is withdrawn |
| resume_lvl | input | CNT_W | Fill level at or below which the request is reissued |
| rx_fill | input | CNT_W | Current receive FIFO occupancy |
| cts_n | input | 1 | Asynchronous active-low clear-to-send from the far end |
| char_bound | input | 1 | One-cycle strobe at a transmit character boundary |
| rts_n | output | 1 | Active-low request-to-send to the far end |
| tx_permit | output | 1 | 1 allows the transmitter to start the next character |

## Verification
The bench builds the block with CNT_W = 4 and SYNC_STAGES = 3. The narrow count lets the fill sweep the whole range, including the largest code 15, so a halt level at full scale and a resume level of zero are both tested. Three synchronizer stages test the generic chain past the minimum depth, and they make the latency of a clear-to-send change visibly longer than two cycles. A loopback phase feeds `rts_n` back into `cts_n`, so the hysteresis, the synchronizer and the boundary gate are all checked together.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   // Receive-side hysteresis state: whether the far end may keep sending.
   typedef enum logic {
      RX_HOLD_OFF = 1'b0,
      RX_CLEAR    = 1'b1
   } rx_room_e;

endpackage

// File: rtl/hsk_cts_sync.sv
module hsk_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);

   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("hsk_cts_sync: STAGES must be at least 2");
   end

   logic [TOP:0] chain_q;

   // Shift toward the top bit; the reset value is the inactive (high) level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[TOP-1:0], async_n};
   end

   assign sync_n = chain_q[TOP];

endmodule

// File: rtl/hsk_rts_hyst.sv
module hsk_rts_hyst
   import hsk_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] fill,
   input  logic [CNT_W-1:0] halt_at,
   input  logic [CNT_W-1:0] resume_at,
   output logic             room
);

   if (CNT_W < 1) begin : g_bad_width
      $error("hsk_rts_hyst: CNT_W must be at least 1");
   end

   rx_room_e room_q;
   logic     at_halt;
   logic     at_resume;

   assign at_halt   = (fill >= halt_at);
   assign at_resume = (fill <= resume_at);

   // Halt has priority; between the two levels the state is kept.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         room_q <= RX_CLEAR;
      else if (at_halt)   room_q <= RX_HOLD_OFF;
      else if (at_resume) room_q <= RX_CLEAR;
   end

   assign room = (room_q == RX_CLEAR);

   AST_HALT_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill >= halt_at) |=> (room_q == RX_HOLD_OFF)); // R2

   AST_RESUME_REISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill < halt_at) && (fill <= resume_at)) |=> (room_q == RX_CLEAR)); // R3

   AST_BAND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill > resume_at) && (fill < halt_at)) |=> $stable(room_q)); // R4

endmodule

// File: rtl/hsk_cts_gate.sv
module hsk_cts_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic cts_active,
   output logic go
);

   logic go_q;

   // Sample clear-to-send only between characters; a started character completes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        go_q <= 1'b0;
      else if (boundary) go_q <= cts_active;
   end

   assign go = go_q;

   AST_GATE_MIDCHAR: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> $stable(go_q)); // R7

   AST_GATE_RESET_CLOSED: assert property (@(posedge clk)
      !rst_n |-> !go_q); // R1

endmodule

// File: rtl/hsk_flow_ctrl.sv
module hsk_flow_ctrl #(
   parameter int CNT_W       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rts_auto_en,
   input  logic             cts_auto_en,
   input  logic             sw_rts,
   input  logic [CNT_W-1:0] halt_lvl,
   input  logic [CNT_W-1:0] resume_lvl,
   input  logic [CNT_W-1:0] rx_fill,
   input  logic             cts_n,
   input  logic             char_bound,
   output logic             rts_n,
   output logic             tx_permit
);

   logic cts_sync_n;
   logic rx_room;
   logic gate_go;

   hsk_cts_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (cts_n),
      .sync_n  (cts_sync_n)
   );

   hsk_rts_hyst #(
      .CNT_W (CNT_W)
   ) u_hyst (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill      (rx_fill),
      .halt_at   (halt_lvl),
      .resume_at (resume_lvl),
      .room      (rx_room)
   );

   hsk_cts_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (char_bound),
      .cts_active (!cts_sync_n),
      .go         (gate_go)
   );

   assign rts_n     = rts_auto_en ? !rx_room : !sw_rts;
   assign tx_permit = cts_auto_en ? gate_go  : 1'b1;

   AST_PERMIT_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_auto_en && !char_bound) |=> (!cts_auto_en || tx_permit == $past(tx_permit))); // R7

   AST_SW_RTS_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts_auto_en && sw_rts) |-> !rts_n); // R5

endmodule

// File: tb/hsk_flow_ctrl_tb.sv
module hsk_flow_ctrl_tb;

   localparam int CW = 4;
   localparam int SS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rts_auto_en = 1'b0;
   logic          cts_auto_en = 1'b0;
   logic          sw_rts = 1'b0;
   logic [CW-1:0] halt_lvl = 4'd12;
   logic [CW-1:0] resume_lvl = 4'd4;
   logic [CW-1:0] rx_fill = '0;
   logic          cts_drv = 1'b1;
   logic          loop_en = 1'b0;
   logic          char_bound = 1'b0;
   logic          rts_n;
   logic          tx_permit;
   logic          cts_n;

   int    vectors = 0;
   int    fails = 0;
   string cur_req = "R1";

   assign cts_n = loop_en ? rts_n : cts_drv;

   always #4 clk = ~clk;

   hsk_flow_ctrl #(.CNT_W(CW), .SYNC_STAGES(SS)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rts_auto_en (rts_auto_en),
      .cts_auto_en (cts_auto_en),
      .sw_rts      (sw_rts),
      .halt_lvl    (halt_lvl),
      .resume_lvl  (resume_lvl),
      .rx_fill     (rx_fill),
      .cts_n       (cts_n),
      .char_bound  (char_bound),
      .rts_n       (rts_n),
      .tx_permit   (tx_permit)
   );

   // Behavioural reference: queue for the synchronizer, bits for the states.
   bit m_sync[$];
   bit m_room = 1'b1;
   bit m_gate = 1'b0;

   initial begin
      for (int i = 0; i < SS; i++) m_sync.push_back(1'b1);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sync.delete();
         for (int i = 0; i < SS; i++) m_sync.push_back(1'b1);
         m_room = 1'b1;
         m_gate = 1'b0;
      end else begin
         if (char_bound) m_gate = !m_sync[0];
         void'(m_sync.pop_front());
         m_sync.push_back(cts_n);
         if (int'(rx_fill) >= int'(halt_lvl))        m_room = 1'b0;
         else if (int'(rx_fill) <= int'(resume_lvl)) m_room = 1'b1;
      end
   end

   always begin
      @(posedge clk);
      #2;
      begin
         logic exp_rts;
         logic exp_go;
         exp_rts = rts_auto_en ? !m_room : !sw_rts;
         exp_go  = cts_auto_en ? m_gate  : 1'b1;
         vectors++;
         if (rts_n !== exp_rts) begin
            fails++;
            $display("FAIL %s rts_n actual=%b expected=%b t=%0t", cur_req, rts_n, exp_rts, $time);
         end
         if (tx_permit !== exp_go) begin
            fails++;
            $display("FAIL %s tx_permit actual=%b expected=%b t=%0t", cur_req, tx_permit, exp_go, $time);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bound_pulse();
      @(negedge clk); char_bound = 1'b1;
      @(negedge clk); char_bound = 1'b0;
   endtask

   task automatic final_report();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      final_report();
   end

   initial begin
      // R1: reset state with both automatic modes on
      cur_req = "R1";
      rts_auto_en = 1'b1; cts_auto_en = 1'b1;
      step(4);
      rst_n = 1'b1;
      step(2);

      // R2: fill ramps up past the halt level
      cur_req = "R2";
      for (int f = 0; f < 16; f++) begin rx_fill = CW'(f); step(1); end
      // R4: draining through the band keeps the request withdrawn
      cur_req = "R4";
      for (int f = 15; f > 4; f--) begin rx_fill = CW'(f); step(2); end
      // R3: reaching the resume level reissues the request
      cur_req = "R3";
      rx_fill = 4'd4; step(2);
      rx_fill = 4'd0; step(2);
      cur_req = "R4";
      rx_fill = 4'd8; step(3);
      // boundary levels: halt at full scale, resume at zero
      cur_req = "R2";
      halt_lvl = 4'd15; resume_lvl = 4'd0;
      rx_fill = 4'd14; step(2);
      rx_fill = 4'd15; step(2);
      cur_req = "R3";
      rx_fill = 4'd1; step(2);
      rx_fill = 4'd0; step(2);

      // R9: overlapping levels, halt wins
      cur_req = "R9";
      halt_lvl = 4'd3; resume_lvl = 4'd8;
      rx_fill = 4'd5; step(2);
      rx_fill = 4'd2; step(2);
      rx_fill = 4'd8; step(2);

      // R5: software-held request, fill ignored
      cur_req = "R5";
      rts_auto_en = 1'b0; halt_lvl = 4'd6; resume_lvl = 4'd2;
      sw_rts = 1'b1; rx_fill = 4'd15; step(2);
      sw_rts = 1'b0; step(1);
      rx_fill = 4'd0; sw_rts = 1'b1; step(2);
      sw_rts = 1'b0; rx_fill = 4'd9; step(2);
      rts_auto_en = 1'b1; rx_fill = 4'd0; step(2);

      // R6/R7: synchronizer latency and boundary-only sampling
      cur_req = "R6";
      cts_drv = 1'b0;
      for (int k = 0; k < 6; k++) bound_pulse();
      cur_req = "R7";
      cts_drv = 1'b1; step(SS + 2);
      step(3);
      bound_pulse();
      cts_drv = 1'b0; step(1);
      bound_pulse(); bound_pulse(); bound_pulse();
      step(SS);
      bound_pulse();
      // pulse inactive then active again between boundaries
      cts_drv = 1'b1; step(1); cts_drv = 1'b0; step(SS + 2);
      bound_pulse();

      // R8: gating disabled
      cur_req = "R8";
      cts_auto_en = 1'b0; cts_drv = 1'b1;
      step(SS + 2); bound_pulse(); step(2);
      cts_drv = 1'b0; bound_pulse(); step(2);

      // R10: loopback of RTS onto CTS
      cur_req = "R10";
      cts_auto_en = 1'b1; rts_auto_en = 1'b1;
      halt_lvl = 4'd10; resume_lvl = 4'd3; rx_fill = 4'd0;
      loop_en = 1'b1;
      step(SS + 2); bound_pulse();
      for (int f = 5; f <= 10; f++) begin rx_fill = CW'(f); step(1); end
      step(SS + 1);
      bound_pulse(); step(1);
      if (tx_permit !== 1'b0) begin
         fails++;
         $display("FAIL R10 tx_permit actual=%b expected=0", tx_permit);
      end
      vectors++;
      rx_fill = 4'd3; step(SS + 2); bound_pulse(); step(1);
      if (tx_permit !== 1'b1) begin
         fails++;
         $display("FAIL R10 tx_permit actual=%b expected=1", tx_permit);
      end
      vectors++;
      loop_en = 1'b0;

      // R1: reset again mid-run
      cur_req = "R1";
      cts_drv = 1'b0; rx_fill = 4'd12;
      step(2);
      rst_n = 1'b0; rx_fill = 4'd0; step(3);
      rst_n = 1'b1; step(3);

      final_report();
   end

endmodule